// File: doc/BRIEF.md
# Serial Character Transmitter

This block turns one parallel character into an asynchronous serial frame on a single output line. A frame is ten bit times long. It starts with a low start bit. Seven data bits follow, least significant first. Then comes a parity bit that makes the total number of ones even, and the frame ends with a high stop bit. A bit counter steps through these states only when the bit-rate tick is high, so the line rate is set entirely by whatever produces the tick.

When no frame is in progress, the counter rests in its stop state and the line stays high. The requester presents a character and holds a send request. The character is captured on the next tick that arrives while the counter is in the stop state. If a request is already waiting when a stop bit ends, the counter goes straight into the next start bit, so frames follow each other with no idle gap. A one-clock done strobe marks the end of each stop bit.

Top module: `ser_char_tx`

## Requirements
- R1: After a synchronous reset (rst high at a clock edge), txd is 1, busy is 0 and done is 0.
- R2: While idle, a send request without a bit tick is not accepted, and a tick without a request starts nothing. In both cases txd stays 1 and busy stays 0.
- R3: A tick that arrives while the counter is in the stop state and send_req is high captures char_in. From the clock edge of that tick, txd is 0 (the start bit) and busy is 1.
- R4: Each later tick advances one bit. The data bits leave in the order char_in[0] first through char_in[6] last, and txd changes only at the edge of a clock in which bit_tick was high.
- R5: The ninth bit time carries the parity bit. With ODD_PARITY=0 it is the XOR of the seven data bits, so data plus parity always hold an even number of ones.
- R6: The tenth bit time is the stop bit, driven as 1. The frame lasts exactly ten ticks from the start bit to the end of the stop bit.
- R7: The tick that ends the stop bit makes done high for exactly one clock, starting at that edge. If no new request is taken at that tick, busy falls to 0 at the same edge.
- R8: If send_req is high at the tick that ends the stop bit, the next frame's start bit (txd=0) begins at that same edge and busy stays 1.
- R9: Once a frame has started, changes to char_in and any send_req pulse before the stop bit ends have no effect on the bits sent.
- R10: Asserting rst in the middle of a frame returns the line to idle (txd=1, busy=0), and the next frame is sent correctly.
- R11: The parity flip-flop is cleared in every start state, so a frame's parity does not depend on the previous character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all logic |
| rst | input | 1 | Synchronous active-high reset to the idle stop state |
| bit_tick | input | 1 | Bit-rate enable; each high cycle advances the frame by one bit |
| send_req | input | 1 | Request to send char_in; taken on a tick in the stop state |
| char_in | input | DATA_W | Character to send |
| txd | output | 1 | Serial data line, high when idle |
| busy | output | 1 | High from frame acceptance until the end of its stop bit |
| done | output | 1 | One-clock strobe at the end of each stop bit |

## Verification
The bench builds the block with its default parameters: DATA_W=7, ODD_PARITY=0 and LSB_FIRST=1. These values give the ten-state frame with even parity and least-significant-first order, and every counter state from start to stop is reached. The bench spaces ticks several clocks apart, so it can show that the line holds steady between ticks. It holds the request across the end of a stop bit to reach the back-to-back rollover. It also sends characters with odd and even numbers of ones, one after another, to show that parity restarts with each frame.

// File: rtl/sctx_pkg.sv
package sctx_pkg;

   // Frame phases decoded from the bit counter
   typedef enum logic [1:0] {
      PH_START  = 2'd0,
      PH_DATA   = 2'd1,
      PH_PARITY = 2'd2,
      PH_STOP   = 2'd3
   } phase_t;

   // Counter layout: 0 = start, 1..dw = data, dw+1 = parity, dw+2 = stop
   function automatic phase_t phase_of(input int unsigned cnt, input int unsigned dw);
      if (cnt == 0)
         return PH_START;
      else if (cnt <= dw)
         return PH_DATA;
      else if (cnt == dw + 1)
         return PH_PARITY;
      else
         return PH_STOP;
   endfunction

endpackage

// File: rtl/sctx_seq.sv
module sctx_seq
   import sctx_pkg::*;
#(
   parameter int DATA_W = 7
) (
   input  logic   clk,
   input  logic   rst,
   input  logic   bit_tick,
   input  logic   go,
   output phase_t phase_o
);

   localparam int LAST_IDX = DATA_W + 2;
   localparam int CNT_W    = $clog2(LAST_IDX + 1);
   localparam logic [CNT_W-1:0] STOP_IDX = CNT_W'(LAST_IDX);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= STOP_IDX;
      end else if (bit_tick) begin
         if (cnt_q == STOP_IDX) begin
            if (go)
               cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   assign phase_o = phase_of(int'(cnt_q), DATA_W);

endmodule

// File: rtl/sctx_hold.sv
module sctx_hold #(
   parameter int DATA_W    = 7,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              shift,
   input  logic [DATA_W-1:0] char_in,
   output logic              cur_bit
);

   logic [DATA_W-1:0] hold_q;

   generate
      if (LSB_FIRST) begin : g_lsb
         always_ff @(posedge clk) begin
            if (rst)
               hold_q <= '0;
            else if (load)
               hold_q <= char_in;
            else if (shift)
               hold_q <= hold_q >> 1;
         end
         assign cur_bit = hold_q[0];
      end else begin : g_msb
         always_ff @(posedge clk) begin
            if (rst)
               hold_q <= '0;
            else if (load)
               hold_q <= char_in;
            else if (shift)
               hold_q <= hold_q << 1;
         end
         assign cur_bit = hold_q[DATA_W-1];
      end
   endgenerate

endmodule

// File: rtl/sctx_par.sv
module sctx_par (
   input  logic clk,
   input  logic rst,
   input  logic clear,
   input  logic step,
   input  logic bit_in,
   output logic par_q
);

   always_ff @(posedge clk) begin
      if (rst || clear)
         par_q <= 1'b0;
      else if (step && bit_in)
         par_q <= ~par_q;
   end

endmodule

// File: rtl/sctx_line.sv
module sctx_line
   import sctx_pkg::*;
#(
   parameter bit ODD_PARITY = 1'b0
) (
   input  phase_t phase,
   input  logic   data_bit,
   input  logic   par_q,
   output logic   txd
);

   logic par_bit;

   generate
      if (ODD_PARITY) begin : g_odd
         assign par_bit = ~par_q;
      end else begin : g_even
         assign par_bit = par_q;
      end
   endgenerate

   always_comb begin
      case (phase)
         PH_START:  txd = 1'b0;
         PH_DATA:   txd = data_bit;
         PH_PARITY: txd = par_bit;
         default:   txd = 1'b1;
      endcase
   end

endmodule

// File: rtl/ser_char_tx.sv
module ser_char_tx
   import sctx_pkg::*;
#(
   parameter int DATA_W     = 7,
   parameter bit ODD_PARITY = 1'b0,
   parameter bit LSB_FIRST  = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bit_tick,
   input  logic              send_req,
   input  logic [DATA_W-1:0] char_in,
   output logic              txd,
   output logic              busy,
   output logic              done
);

   generate
      if (DATA_W < 2 || DATA_W > 32) begin : g_bad_width
         $error("ser_char_tx: DATA_W must lie in 2..32");
      end
   endgenerate

   phase_t phase;
   logic   accept;
   logic   in_stop;
   logic   data_bit;
   logic   par_q;
   logic   busy_q;
   logic   done_q;

   assign in_stop = (phase == PH_STOP);
   assign accept  = in_stop && bit_tick && send_req;

   sctx_seq #(.DATA_W(DATA_W)) u_seq (
      .clk      (clk),
      .rst      (rst),
      .bit_tick (bit_tick),
      .go       (send_req),
      .phase_o  (phase)
   );

   sctx_hold #(.DATA_W(DATA_W), .LSB_FIRST(LSB_FIRST)) u_hold (
      .clk     (clk),
      .rst     (rst),
      .load    (accept),
      .shift   (bit_tick && (phase == PH_DATA)),
      .char_in (char_in),
      .cur_bit (data_bit)
   );

   sctx_par u_par (
      .clk    (clk),
      .rst    (rst),
      .clear  (phase == PH_START),
      .step   (bit_tick && (phase == PH_DATA)),
      .bit_in (data_bit),
      .par_q  (par_q)
   );

   sctx_line #(.ODD_PARITY(ODD_PARITY)) u_line (
      .phase    (phase),
      .data_bit (data_bit),
      .par_q    (par_q),
      .txd      (txd)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= in_stop && bit_tick && busy_q;
         if (accept)
            busy_q <= 1'b1;
         else if (in_stop && bit_tick)
            busy_q <= 1'b0;
      end
   end

   assign busy = busy_q;
   assign done = done_q;

endmodule

// File: rtl/sctx_chk.sv
module sctx_chk #(
   parameter int DATA_W = 7
) (
   input logic clk,
   input logic rst,
   input logic bit_tick,
   input logic txd,
   input logic busy,
   input logic done
);

   localparam int unsigned BUSY_TICKS = DATA_W + 2;

   int unsigned tick_n;

   always_ff @(posedge clk) begin
      if (rst)
         tick_n <= 0;
      else if (bit_tick && busy)
         tick_n <= (tick_n == BUSY_TICKS) ? 0 : tick_n + 1;
   end

   // R1
   idle_mark_chk: assert property (@(posedge clk) disable iff (rst)
      !busy |-> txd);

   // R3
   start_low_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> !txd);

   // R4
   line_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(bit_tick)) |-> $stable(txd));

   // R6
   frame_len_chk: assert property (@(posedge clk) disable iff (rst)
      done |-> ($past(tick_n) == BUSY_TICKS));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R8
   chain_start_chk: assert property (@(posedge clk) disable iff (rst)
      (done && busy) |-> !txd);

endmodule

bind ser_char_tx sctx_chk #(.DATA_W(DATA_W)) u_sctx_chk (
   .clk      (clk),
   .rst      (rst),
   .bit_tick (bit_tick),
   .txd      (txd),
   .busy     (busy),
   .done     (done)
);

// File: tb/test_ser_char_tx.sv
module test_ser_char_tx;

   localparam int DW = 7;

   logic          clk = 1'b0;
   logic          rst;
   logic          bit_tick;
   logic          send_req;
   logic [DW-1:0] char_in;
   logic          txd;
   logic          busy;
   logic          done;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   ser_char_tx #(.DATA_W(DW), .ODD_PARITY(1'b0), .LSB_FIRST(1'b1)) i_ser_char_tx (
      .clk      (clk),
      .rst      (rst),
      .bit_tick (bit_tick),
      .send_req (send_req),
      .char_in  (char_in),
      .txd      (txd),
      .busy     (busy),
      .done     (done)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic tick_pulse();
      @(negedge clk) bit_tick = 1'b1;
      @(negedge clk) bit_tick = 1'b0;
   endtask

   // Send one frame and check every bit; optionally chain a next request
   task automatic xmit(input logic [DW-1:0] ch, input bit started,
                       input bit chain, input logic [DW-1:0] nxt, input bit poke);
      logic exp_bit;
      if (!started) begin
         send_req = 1'b1;
         char_in  = ch;
         tick_pulse();
      end
      send_req = 1'b0;
      char_in  = ~ch;
      chk(txd == 1'b0, "R3 start bit", txd, 0);
      chk(busy == 1'b1, "R3 busy at start", busy, 1);
      for (int i = 1; i <= 9; i++) begin
         send_req = (poke && i >= 2 && i <= 4);
         tick_pulse();
         if (i <= DW)          exp_bit = ch[i-1];
         else if (i == DW + 1) exp_bit = ^ch;
         else                  exp_bit = 1'b1;
         if (i <= DW)
            chk(txd == exp_bit, "R4 R9 data bit", txd, exp_bit);
         else if (i == DW + 1)
            chk(txd == exp_bit, "R5 R11 parity bit", txd, exp_bit);
         else
            chk(txd == 1'b1, "R6 stop bit", txd, 1);
         repeat (2) @(negedge clk);
         chk(txd == exp_bit, "R4 line held between ticks", txd, exp_bit);
      end
      send_req = chain;
      char_in  = nxt;
      tick_pulse();
      chk(done == 1'b1, "R7 done after stop", done, 1);
      chk(busy == chain, "R7 R8 busy after stop", busy, chain);
      chk(txd == !chain, "R8 line after stop", txd, !chain);
      send_req = 1'b0;
      @(negedge clk);
      chk(done == 1'b0, "R7 done one clock", done, 0);
   endtask

   task automatic t_reset();
      rst = 1'b1; bit_tick = 1'b0; send_req = 1'b0; char_in = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk(txd == 1'b1, "R1 txd after reset", txd, 1);
      chk(busy == 1'b0, "R1 busy after reset", busy, 0);
      chk(done == 1'b0, "R1 done after reset", done, 0);
   endtask

   task automatic t_idle_ignore();
      send_req = 1'b1;
      char_in  = 7'h55;
      repeat (5) @(negedge clk);
      chk(busy == 1'b0, "R2 request without tick", busy, 0);
      chk(txd == 1'b1, "R2 line idle without tick", txd, 1);
      send_req = 1'b0;
      tick_pulse();
      chk(busy == 1'b0, "R2 tick without request", busy, 0);
      chk(txd == 1'b1, "R2 line after bare tick", txd, 1);
      chk(done == 1'b0, "R2 no done on bare tick", done, 0);
   endtask

   task automatic t_single_frames();
      xmit(7'h41, 1'b0, 1'b0, '0, 1'b1);
      xmit(7'h00, 1'b0, 1'b0, '0, 1'b0);
      xmit(7'h7F, 1'b0, 1'b0, '0, 1'b1);
      repeat (3) @(negedge clk);
      chk(txd == 1'b1, "R6 idle after frames", txd, 1);
   endtask

   task automatic t_back_to_back();
      xmit(7'h01, 1'b0, 1'b1, 7'h03, 1'b0);
      xmit(7'h03, 1'b1, 1'b1, 7'h2A, 1'b1);
      xmit(7'h2A, 1'b1, 1'b0, '0, 1'b0);
   endtask

   task automatic t_reset_mid();
      send_req = 1'b1;
      char_in  = 7'h5A;
      tick_pulse();
      send_req = 1'b0;
      repeat (3) tick_pulse();
      @(negedge clk) rst = 1'b1;
      @(negedge clk) rst = 1'b0;
      chk(txd == 1'b1, "R10 txd after mid reset", txd, 1);
      chk(busy == 1'b0, "R10 busy after mid reset", busy, 0);
      chk(done == 1'b0, "R10 done after mid reset", done, 0);
      xmit(7'h36, 1'b0, 1'b0, '0, 1'b0);
   endtask

   initial begin
      t_reset();
      t_idle_ignore();
      t_single_frames();
      t_back_to_back();
      t_reset_mid();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule